// File: doc/BRIEF.md
# Level Interrupt Combiner with Sequential Dispatcher

The block gathers a parameterised number of level-sensitive interrupt lines into a single summary request for a parent interrupt controller. The summary is the plain OR of every line, whatever the enable state. The raw line levels are also packed into 32-bit status words. Line n sits at bit n mod 32 of word n div 32, and only the last word may be partially filled. A combinational read port returns these words. There is no way to write them.

A per-line enable mask is kept inside the block. Configuration requests address one line by its interrupt number and either set (unmask) or clear (mask) that line's enable bit. Only level triggering is supported. A request that asks for an edge trigger, or that names a number outside the configured range, is refused with an error pulse and changes nothing.

A scan starts on a start pulse, or on a rising summary while the dispatcher is idle. The dispatcher visits the status words from word 0 upward. At each word it takes a snapshot of the enabled pending bits. It then hands out one interrupt number per valid/ready transfer, lowest bit first. The number stays on the output until the consumer accepts it. While `disp_ready` is low, `disp_valid` and `disp_num` hold and the scan waits. A word with nothing enabled pending produces a one-cycle spurious flag carrying that word's index. A one-cycle done pulse ends the scan.

Top module: `lvl_irq_combiner`

## Requirements
- R1: `irq_summary` is high in the same cycle whenever any input line is high, regardless of the enable mask, and low when all lines are low.
- R2: `rd_data` for word w returns line w*32+b at bit b. Bits whose line number is at or above NUM_LINES read as 0.
- R3: After reset all enable bits are 0, the dispatcher is idle, and `disp_valid`, `spur_valid`, `scan_done`, `cfg_ack` and `cfg_err` are all low.
- R4: A configuration request with `cfg_unmask`=1 sets the enable bit of line `cfg_num`, and with `cfg_unmask`=0 it clears it. `cfg_ack` pulses one cycle after the request.
- R5: A request with `cfg_edge`=1 (edge trigger asked for), or with `cfg_num` >= NUM_LINES, pulses `cfg_err` instead of `cfg_ack` one cycle later and leaves every enable bit unchanged.
- R6: A scan starts on `scan_start` or on a 0-to-1 change of the summary while idle. Both triggers are ignored while a scan is in progress.
- R7: Within a scan, only lines that are both high and enabled are emitted. The order is ascending word index, then lowest bit first, and the number is word*32+bit.
- R8: When a visited word has no enabled pending bit, `spur_valid` is high for exactly one cycle with `spur_word` equal to that word's index.
- R9: While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and `disp_num` stays unchanged.
- R10: A word's pending set is captured when the scan reaches that word. Later input changes do not change what is emitted for that word.
- R11: `scan_done` pulses for one cycle after the last word is processed. Each word takes one visiting cycle plus one cycle per emitted number, so a scan with no emitted numbers raises done in the fifth cycle after the trigger for four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Level interrupt lines |
| irq_summary | output | 1 | OR of all lines |
| rd_addr | input | WIDX_W | Status word index to read |
| rd_data | output | 32 | Selected status word |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_unmask | input | 1 | 1 = set enable, 0 = clear enable |
| cfg_edge | input | 1 | 1 = request asks for edge trigger (refused) |
| cfg_num | input | NUM_W | Interrupt number addressed |
| cfg_ack | output | 1 | Request accepted (one cycle after) |
| cfg_err | output | 1 | Request refused (one cycle after) |
| scan_start | input | 1 | Start a scan when idle |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| disp_valid | output | 1 | Dispatched number valid |
| disp_ready | input | 1 | Consumer accepts number |
| disp_num | output | NUM_W | Dispatched interrupt number |
| spur_valid | output | 1 | One-cycle spurious-word flag |
| spur_word | output | WIDX_W | Index of the spurious word |

## Verification
The summary and the read data are combinational, so they are checked in the same cycle as the line change. Configuration answers are registered and are sampled one cycle after the request. In a scan, a trigger seen at a clock edge puts word 0 under visit in the next cycle, and each word then takes one visiting cycle plus one cycle per accepted number. For an all-spurious scan, the bench counts falling edges from the trigger and requires done on the fifth. Dispatches and spurious flags are compared against queued expectations at the falling edge where the transfer or flag is visible, under both full-rate and randomly stalled ready.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int WORD_BITS = 32;
  localparam int BIT_W     = 5;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_LOAD,
    SC_SERVE,
    SC_DONE
  } scan_state_t;

  function automatic logic [BIT_W-1:0] lowest_set(input logic [WORD_BITS-1:0] v);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = WORD_BITS - 1; i >= 0; i--) begin
      if (v[i]) r = BIT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/lic_status_pack.sv
module lic_status_pack
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 100,
  parameter int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS
) (
  input  logic [NUM_LINES-1:0]                 irq_in,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  status_words,
  output logic                                 summary
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
      if (w * WORD_BITS + b < NUM_LINES) begin : g_live
        assign status_words[w][b] = irq_in[w*WORD_BITS+b];
      end else begin : g_pad
        assign status_words[w][b] = 1'b0;
      end
    end
  end

  assign summary = |irq_in;
endmodule

// File: rtl/lic_enable_bank.sv
module lic_enable_bank
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 100,
  parameter int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS,
  parameter int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int NUM_W     = WIDX_W + BIT_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_valid,
  input  logic                                 cfg_unmask,
  input  logic                                 cfg_edge,
  input  logic [NUM_W-1:0]                     cfg_num,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  en_words,
  output logic                                 cfg_ack,
  output logic                                 cfg_err
);
  logic              num_ok;
  logic              req_ok;
  logic [WIDX_W-1:0] sel_word;
  logic [BIT_W-1:0]  sel_bit;

  assign num_ok   = ({1'b0, cfg_num} < (NUM_W+1)'(NUM_LINES));
  assign req_ok   = cfg_valid && num_ok && !cfg_edge;
  assign sel_word = cfg_num[NUM_W-1:BIT_W];
  assign sel_bit  = cfg_num[BIT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_words <= '0;
      cfg_ack  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_ack <= req_ok;
      cfg_err <= cfg_valid && !req_ok;
      if (req_ok) en_words[sel_word][sel_bit] <= cfg_unmask;
    end
  end

  AST_REJECT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(en_words)); // R5
  AST_ACK_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid) |-> (cfg_ack != cfg_err)); // R4
endmodule

// File: rtl/lic_scanner.sv
module lic_scanner
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 100,
  parameter int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS,
  parameter int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int NUM_W     = WIDX_W + BIT_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WORDS-1:0][WORD_BITS-1:0]  status_words,
  input  logic [NUM_WORDS-1:0][WORD_BITS-1:0]  en_words,
  input  logic                                 summary,
  input  logic                                 scan_start,
  input  logic                                 disp_ready,
  output logic                                 disp_valid,
  output logic [NUM_W-1:0]                     disp_num,
  output logic                                 spur_valid,
  output logic [WIDX_W-1:0]                    spur_word,
  output logic                                 scan_done
);
  scan_state_t          state_q;
  logic [WIDX_W-1:0]    word_q;
  logic [WORD_BITS-1:0] work_q;
  logic                 sum_q;

  logic [WORD_BITS-1:0] pend_cur;
  logic [WORD_BITS-1:0] work_clr;
  logic [BIT_W-1:0]     pick;
  logic                 last_word;
  logic                 trigger;

  assign pend_cur  = status_words[word_q] & en_words[word_q];
  assign pick      = lowest_set(work_q);
  assign work_clr  = work_q & ~(WORD_BITS'(1) << pick);
  assign last_word = (word_q == WIDX_W'(NUM_WORDS - 1));
  assign trigger   = scan_start || (summary && !sum_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      word_q  <= '0;
      work_q  <= '0;
      sum_q   <= 1'b0;
    end else begin
      sum_q <= summary;
      unique case (state_q)
        SC_IDLE: begin
          if (trigger) begin
            word_q  <= '0;
            state_q <= SC_LOAD;
          end
        end
        SC_LOAD: begin
          work_q <= pend_cur;
          if (pend_cur != '0) begin
            state_q <= SC_SERVE;
          end else if (last_word) begin
            state_q <= SC_DONE;
          end else begin
            word_q <= word_q + 1'b1;
          end
        end
        SC_SERVE: begin
          if (disp_ready) begin
            work_q <= work_clr;
            if (work_clr == '0) begin
              if (last_word) begin
                state_q <= SC_DONE;
              end else begin
                word_q  <= word_q + 1'b1;
                state_q <= SC_LOAD;
              end
            end
          end
        end
        SC_DONE: state_q <= SC_IDLE;
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assign disp_valid = (state_q == SC_SERVE);
  assign disp_num   = {word_q, pick};
  assign spur_valid = (state_q == SC_LOAD) && (pend_cur == '0);
  assign spur_word  = word_q;
  assign scan_done  = (state_q == SC_DONE);

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_num))); // R9
  AST_DISP_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (!disp_valid || (disp_num > $past(disp_num)))); // R7
  AST_DISP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ({1'b0, disp_num} < (NUM_W+1)'(NUM_LINES))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (!scan_done && !disp_valid && !spur_valid)); // R11
endmodule

// File: rtl/lvl_irq_combiner.sv
module lvl_irq_combiner
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 100,
  localparam int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int NUM_W     = WIDX_W + BIT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_in,
  output logic                  irq_summary,
  input  logic [WIDX_W-1:0]     rd_addr,
  output logic [WORD_BITS-1:0]  rd_data,
  input  logic                  cfg_valid,
  input  logic                  cfg_unmask,
  input  logic                  cfg_edge,
  input  logic [NUM_W-1:0]      cfg_num,
  output logic                  cfg_ack,
  output logic                  cfg_err,
  input  logic                  scan_start,
  output logic                  scan_done,
  output logic                  disp_valid,
  input  logic                  disp_ready,
  output logic [NUM_W-1:0]      disp_num,
  output logic                  spur_valid,
  output logic [WIDX_W-1:0]     spur_word
);
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] status_words;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] en_words;

  lic_status_pack #(.NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS)) u_pack (
    .irq_in       (irq_in),
    .status_words (status_words),
    .summary      (irq_summary)
  );

  lic_enable_bank #(
    .NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W), .NUM_W(NUM_W)
  ) u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_unmask (cfg_unmask),
    .cfg_edge   (cfg_edge),
    .cfg_num    (cfg_num),
    .en_words   (en_words),
    .cfg_ack    (cfg_ack),
    .cfg_err    (cfg_err)
  );

  lic_scanner #(
    .NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W), .NUM_W(NUM_W)
  ) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_words (status_words),
    .en_words     (en_words),
    .summary      (irq_summary),
    .scan_start   (scan_start),
    .disp_ready   (disp_ready),
    .disp_valid   (disp_valid),
    .disp_num     (disp_num),
    .spur_valid   (spur_valid),
    .spur_word    (spur_word),
    .scan_done    (scan_done)
  );

  always_comb begin
    rd_data = '0;
    if ({1'b0, rd_addr} < (WIDX_W+1)'(NUM_WORDS)) rd_data = status_words[rd_addr];
  end

  AST_SUMMARY_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_summary && !$past(irq_summary) && !$past(disp_valid) && !$past(scan_start)
      && !$past(spur_valid)) |-> !disp_valid); // R6
endmodule

// File: tb/lvl_irq_combiner_tb_top.sv
module lvl_irq_combiner_tb_top;
  localparam int NL = 100;
  localparam int NWORD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic        irq_summary;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cfg_valid = 1'b0, cfg_unmask = 1'b0, cfg_edge = 1'b0;
  logic [6:0]  cfg_num = '0;
  logic        cfg_ack, cfg_err;
  logic        scan_start = 1'b0, scan_done;
  logic        disp_valid, disp_ready = 1'b1;
  logic [6:0]  disp_num;
  logic        spur_valid;
  logic [1:0]  spur_word;

  always #4 clk = ~clk;

  lvl_irq_combiner #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_summary(irq_summary),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_valid(cfg_valid), .cfg_unmask(cfg_unmask), .cfg_edge(cfg_edge),
    .cfg_num(cfg_num), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .scan_start(scan_start), .scan_done(scan_done),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_num(disp_num),
    .spur_valid(spur_valid), .spur_word(spur_word)
  );

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int exp_disp[$];
  int exp_spur[$];
  logic [NL-1:0] model_en = '0;
  int bp_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (bp_mode == 0) disp_ready = 1'b1;
    else if (bp_mode == 1) disp_ready = lfsr[0];
    else disp_ready = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (disp_valid && disp_ready) begin
        if (exp_disp.size() == 0) chk(0, "R7 unexpected dispatch", disp_num, -1);
        else begin
          int e;
          e = exp_disp.pop_front();
          chk(disp_num == e, "R7 dispatch order", disp_num, e);
        end
      end
      if (spur_valid) begin
        if (exp_spur.size() == 0) chk(0, "R8 unexpected spurious", spur_word, -1);
        else begin
          int e;
          e = exp_spur.pop_front();
          chk(spur_word == e, "R8 spurious word", spur_word, e);
        end
      end
      if (scan_done) done_cnt++;
    end
  end

  task automatic push_expect();
    for (int w = 0; w < NWORD; w++) begin
      bit any;
      any = 0;
      for (int b = 0; b < 32; b++) begin
        int n;
        n = w * 32 + b;
        if (n < NL && irq_in[n] && model_en[n]) begin
          exp_disp.push_back(n);
          any = 1;
        end
      end
      if (!any) exp_spur.push_back(w);
    end
  endtask

  task automatic wait_done();
    int c0;
    int k;
    c0 = done_cnt;
    k = 0;
    while (done_cnt == c0 && k < 3000) begin
      @(negedge clk); #1;
      k++;
    end
    chk(done_cnt == c0 + 1, "R11 scan done seen", done_cnt - c0, 1);
    chk(exp_disp.size() == 0, "R7 all dispatches seen", exp_disp.size(), 0);
    chk(exp_spur.size() == 0, "R8 all spurious seen", exp_spur.size(), 0);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 scan_start = 1'b1;
    @(negedge clk); #1 scan_start = 1'b0;
  endtask

  task automatic cfg(input bit unmask, input bit edge_req, input int num, input bit expect_ok);
    @(negedge clk); #1;
    cfg_valid = 1'b1; cfg_unmask = unmask; cfg_edge = edge_req; cfg_num = 7'(num);
    @(negedge clk); #1;
    cfg_valid = 1'b0; cfg_edge = 1'b0;
    #1;
    if (expect_ok) begin
      chk(cfg_ack == 1 && cfg_err == 0, "R4 request acknowledged", {cfg_ack, cfg_err}, 2);
      model_en[num] = unmask;
    end else begin
      chk(cfg_ack == 0 && cfg_err == 1, "R5 request refused", {cfg_ack, cfg_err}, 1);
    end
  endtask

  task automatic read_word(input int w, input logic [31:0] exp, input string req);
    @(negedge clk); #1 rd_addr = 2'(w);
    #1 chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R3 reset state
    chk(disp_valid == 0 && spur_valid == 0 && scan_done == 0, "R3 outputs idle in reset",
        {disp_valid, spur_valid, scan_done}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cfg_ack == 0 && cfg_err == 0 && disp_valid == 0, "R3 idle after reset",
        {cfg_ack, cfg_err, disp_valid}, 0);

    // R6 rising summary trigger, R3 enables zero, R11 done timing
    push_expect();
    irq_in[98] = 1'b1;
    push_expect();
    exp_spur.delete();
    for (int w = 0; w < NWORD; w++) exp_spur.push_back(w);
    begin
      int k;
      int got;
      got = 0;
      for (k = 1; k <= 8 && got == 0; k++) begin
        @(negedge clk); #1;
        if (scan_done) got = k;
      end
      chk(got == 5, "R11 done cycle of empty scan", got, 5);
    end
    chk(exp_spur.size() == 0, "R3 enables zero so all words spurious", exp_spur.size(), 0);

    // R1 summary, R2 packing
    #1 chk(irq_summary == 1, "R1 summary with one line", irq_summary, 1);
    read_word(3, 32'h4, "R2 partial word packing");
    read_word(0, 32'h0, "R2 empty word");

    // R4 / R5 configuration
    cfg(1, 1, 5, 0);
    cfg(1, 0, 100, 0);
    cfg(1, 0, 127, 0);
    cfg(1, 0, 3, 1);
    cfg(1, 0, 7, 1);
    cfg(1, 0, 40, 1);
    cfg(1, 0, 63, 1);
    cfg(1, 0, 97, 1);

    // R7 main scan with random backpressure
    @(negedge clk); #1;
    irq_in[3] = 1; irq_in[5] = 1; irq_in[7] = 1; irq_in[10] = 1;
    irq_in[40] = 1; irq_in[63] = 1; irq_in[97] = 1;
    #1;
    read_word(0, 32'h0000_04a8, "R2 word0 bits");
    read_word(1, 32'h8000_0100, "R2 word1 bits");
    read_word(3, 32'h0000_0006, "R2 word3 bits");
    bp_mode = 1;
    push_expect();
    pulse_start();
    wait_done();
    bp_mode = 0;

    // R4 mask removes lines
    cfg(0, 0, 7, 1);
    cfg(0, 0, 63, 1);
    push_expect();
    chk(exp_disp.size() == 3, "R4 expected set after mask", exp_disp.size(), 3);
    pulse_start();
    wait_done();

    // R8 spurious mix
    @(negedge clk); #1;
    irq_in = '0; irq_in[98] = 1; irq_in[3] = 1;
    push_expect();
    pulse_start();
    wait_done();

    // R10 snapshot, R9 hold, R6 start ignored while busy
    cfg(1, 0, 0, 1);
    cfg(1, 0, 1, 1);
    cfg(1, 0, 2, 1);
    @(negedge clk); #1;
    irq_in = '0; irq_in[98] = 1; irq_in[0] = 1; irq_in[1] = 1; irq_in[2] = 1;
    push_expect();
    bp_mode = 2;
    pulse_start();
    begin
      int k;
      k = 0;
      while (!disp_valid && k < 50) begin @(negedge clk); #1; k++; end
    end
    chk(disp_valid == 1 && disp_num == 0, "R7 first number of word0", disp_num, 0);
    irq_in[1] = 0; irq_in[2] = 0;
    scan_start = 1'b1;
    @(negedge clk); #1 scan_start = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(disp_valid == 1 && disp_num == 0, "R9 held under stall", disp_num, 0);
    bp_mode = 0;
    wait_done();
    begin
      int c0;
      c0 = done_cnt;
      repeat (12) @(negedge clk);
      #1 chk(done_cnt == c0, "R6 start during scan ignored", done_cnt - c0, 0);
    end
    chk(exp_disp.size() == 0, "R10 snapshot kept lines 1 and 2", exp_disp.size(), 0);

    // R6 rising summary while idle, R1 low summary
    @(negedge clk); #1 irq_in = '0;
    #1 chk(irq_summary == 0, "R1 summary low", irq_summary, 1'b0);
    begin
      int c0;
      c0 = done_cnt;
      repeat (6) @(negedge clk);
      #1 chk(done_cnt == c0, "R6 no scan without trigger", done_cnt - c0, 0);
    end
    @(negedge clk); #1 irq_in[40] = 1;
    push_expect();
    wait_done();

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule